// File: doc/BRIEF.md
# Cascadable Presettable Counter

This block is a small synchronous up-counter with a parallel preset. Two build-time choices shape it. One sets whether it counts in binary, using the full range of its width, or as a decade, running 0 to 9. The other sets whether the active-low clear acts at once or waits for a rising clock edge. Loading and counting both happen only on the rising edge of the clock.

Wider counters are built by chaining stages. The terminal-count output of a stage goes into the carry input of the stage above it. That output is high while the stage sits at its last value and its own carry input is high. The stage above therefore advances exactly once per full cycle of the stage below, for one clock period. The terminal count ignores the plain count enable. As a result, a stalled lower stage still gives the upper stage a correct view of whether a carry is pending.

Top module: `presettable_cnt`

## Requirements
- R1: In binary mode, with load_n high and both cnt_en and carry_in high, count rises by one at each rising clock edge and wraps from 15 to 0 (4-bit default).
- R2: In decade mode, counting steps 0,1,...,9 and then returns to 0.
- R3: In decade mode, a count holding any of the values 10 to 15 becomes 0 after a single count step.
- R4: With rst_n high and load_n low, count takes the value of din at the rising edge, whatever cnt_en and carry_in are.
- R5: With rst_n and load_n high and either cnt_en or carry_in low, count keeps its value across the edge.
- R6: carry_out is 1 exactly when carry_in is 1 and count equals the last value (15 binary, 9 decade). It does not depend on cnt_en.
- R7: A low rst_n forces count to 0 and overrides load_n, cnt_en and carry_in. The reset state is count 0.
- R8: In asynchronous-clear mode, count becomes 0 as soon as rst_n falls, with no clock edge needed.
- R9: In synchronous-clear mode, a falling rst_n leaves count unchanged until the next rising edge, which clears it.
- R10: With a lower stage's carry_out wired to an upper stage's carry_in, the two stages count as one counter from 0 to 255 (binary) or 0 to 99 (decade) and then wrap to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low clear, asynchronous or synchronous by parameter |
| load_n | input | 1 | Active-low parallel preset enable |
| din | input | WIDTH | Preset value |
| cnt_en | input | 1 | Count enable, does not gate carry_out |
| carry_in | input | 1 | Count enable that also gates carry_out; fed from the stage below |
| count | output | WIDTH | Current count |
| carry_out | output | 1 | Terminal count, feeds the stage above |

## Verification
On every cycle the assertions check the following:
- loads take din;
- a disabled counter holds its value;
- a binary step adds one;
- a decade counter at 9 or above goes to 0;
- carry_out is never high without carry_in or away from the last value;
- a sampled clear gives 0 one edge later.

Only the bench's scenarios can show the remaining behaviour. This covers the difference between the two clear styles when rst_n falls in the middle of a clock period. It also covers the full two-stage sweep through 255 and 99 with the wrap to zero, and the fact that carry_out stays high while cnt_en is low.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
   typedef enum logic [1:0] {
      OP_CLEAR = 2'd0,
      OP_LOAD  = 2'd1,
      OP_STEP  = 2'd2,
      OP_KEEP  = 2'd3
   } pcnt_op_e;
endpackage

// File: rtl/pcnt_ctrl.sv
module pcnt_ctrl
   import pcnt_pkg::*;
(
   input  logic     clr_req,
   input  logic     load_n,
   input  logic     cnt_en,
   input  logic     carry_in,
   output pcnt_op_e op
);
   // priority: clear, load, step, keep
   always_comb begin
      if (clr_req)                op = OP_CLEAR;
      else if (!load_n)           op = OP_LOAD;
      else if (cnt_en && carry_in) op = OP_STEP;
      else                        op = OP_KEEP;
   end
endmodule

// File: rtl/pcnt_next.sv
module pcnt_next
   import pcnt_pkg::*;
#(
   parameter int WIDTH  = 4,
   parameter bit DECADE = 1'b0
) (
   input  pcnt_op_e         op,
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] nxt
);
   localparam logic [WIDTH-1:0] DEC_LAST = WIDTH'(9);

   logic [WIDTH-1:0] inc;

   generate
      if (DECADE) begin : g_dec
         // 9 and every illegal value fold to 0 in one step
         always_comb inc = (cur >= DEC_LAST) ? '0 : cur + 1'b1;
      end else begin : g_bin
         always_comb inc = cur + 1'b1;
      end
   endgenerate

   always_comb begin
      unique case (op)
         OP_CLEAR: nxt = '0;
         OP_LOAD:  nxt = din;
         OP_STEP:  nxt = inc;
         default:  nxt = cur;
      endcase
   end
endmodule

// File: rtl/pcnt_term.sv
module pcnt_term #(
   parameter int WIDTH  = 4,
   parameter bit DECADE = 1'b0
) (
   input  logic [WIDTH-1:0] cur,
   input  logic             carry_in,
   output logic             carry_out
);
   localparam int               LAST_INT = DECADE ? 9 : (2 ** WIDTH) - 1;
   localparam logic [WIDTH-1:0] LAST     = WIDTH'(LAST_INT);

   assign carry_out = carry_in && (cur == LAST);
endmodule

// File: rtl/presettable_cnt.sv
module presettable_cnt
   import pcnt_pkg::*;
#(
   parameter int WIDTH     = 4,
   parameter bit DECADE    = 1'b0,
   parameter bit ASYNC_CLR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_n,
   input  logic [WIDTH-1:0] din,
   input  logic             cnt_en,
   input  logic             carry_in,
   output logic [WIDTH-1:0] count,
   output logic             carry_out
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("presettable_cnt: WIDTH must be at least 1");
      end
      if (DECADE && (WIDTH < 4)) begin : g_bad_decade
         $error("presettable_cnt: decade mode needs WIDTH of 4 or more");
      end
   endgenerate

   logic [WIDTH-1:0] q;
   logic [WIDTH-1:0] q_nxt;
   logic             clr_req;
   pcnt_op_e         op;

   generate
      if (ASYNC_CLR) begin : g_aclr
         assign clr_req = 1'b0;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= q_nxt;
         end
      end else begin : g_sclr
         assign clr_req = !rst_n;
         always_ff @(posedge clk) begin
            q <= q_nxt;
         end
      end
   endgenerate

   pcnt_ctrl u_ctrl (
      .clr_req  (clr_req),
      .load_n   (load_n),
      .cnt_en   (cnt_en),
      .carry_in (carry_in),
      .op       (op)
   );

   pcnt_next #(.WIDTH(WIDTH), .DECADE(DECADE)) u_next (
      .op  (op),
      .cur (q),
      .din (din),
      .nxt (q_nxt)
   );

   pcnt_term #(.WIDTH(WIDTH), .DECADE(DECADE)) u_term (
      .cur       (q),
      .carry_in  (carry_in),
      .carry_out (carry_out)
   );

   assign count = q;
endmodule

// File: rtl/presettable_cnt_chk.sv
module presettable_cnt_chk #(
   parameter int WIDTH     = 4,
   parameter bit DECADE    = 1'b0,
   parameter bit ASYNC_CLR = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             load_n,
   input logic [WIDTH-1:0] din,
   input logic             cnt_en,
   input logic             carry_in,
   input logic [WIDTH-1:0] count,
   input logic             carry_out
);
   localparam int               LAST_INT = DECADE ? 9 : (2 ** WIDTH) - 1;
   localparam logic [WIDTH-1:0] LAST     = WIDTH'(LAST_INT);

   // R4
   load_takes_din_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_n |=> count == $past(din));

   // R5
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && !(cnt_en && carry_in)) |=> $stable(count));

   // R6
   carry_needs_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
      carry_out |-> carry_in);

   // R6
   carry_at_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      carry_out |-> count == LAST);

   // R7: no disable, a sampled clear must yield 0 at the next edge in both styles
   clear_gives_zero_chk: assert property (@(posedge clk)
      !rst_n |=> count == '0);

   generate
      if (DECADE) begin : g_dec_chk
         // R3
         decade_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (load_n && cnt_en && carry_in && count >= WIDTH'(9)) |=> count == '0);
      end else begin : g_bin_chk
         // R1
         binary_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (load_n && cnt_en && carry_in) |=> count == WIDTH'($past(count) + 1'b1));
      end
   endgenerate
endmodule

bind presettable_cnt presettable_cnt_chk #(
   .WIDTH(WIDTH), .DECADE(DECADE), .ASYNC_CLR(ASYNC_CLR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din),
   .cnt_en(cnt_en), .carry_in(carry_in), .count(count), .carry_out(carry_out)
);

// File: tb/tb_presettable_cnt.sv
module tb_presettable_cnt;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load_n = 1'b1;
   logic [3:0] din_lo = 4'd0;
   logic [3:0] din_hi = 4'd0;
   logic       cnt_en = 1'b0;
   logic       carry_in = 1'b0;

   logic [3:0] a_lo, a_hi, b_lo, b_hi;
   logic       ca_lo, ca_hi, cb_lo, cb_hi;

   always #4 clk = ~clk;

   // chain A: binary, asynchronous clear
   presettable_cnt #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din_lo),
      .cnt_en(cnt_en), .carry_in(carry_in), .count(a_lo), .carry_out(ca_lo));
   presettable_cnt #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b1)) dut_hi (
      .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din_hi),
      .cnt_en(cnt_en), .carry_in(ca_lo), .count(a_hi), .carry_out(ca_hi));
   // chain B: decade, synchronous clear
   presettable_cnt #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLR(1'b0)) dec_lo (
      .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din_lo),
      .cnt_en(cnt_en), .carry_in(carry_in), .count(b_lo), .carry_out(cb_lo));
   presettable_cnt #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLR(1'b0)) dec_hi (
      .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din_hi),
      .cnt_en(cnt_en), .carry_in(cb_lo), .count(b_hi), .carry_out(cb_hi));

   typedef struct {
      logic [3:0] al, ah, bl, bh;
      logic       ta, tb;
      string      tag;
   } exp_t;

   exp_t q[$];
   int   total = 0;
   int   bad = 0;
   logic [3:0] ma_l = 0, ma_h = 0, mb_l = 0, mb_h = 0;

   function automatic logic [3:0] mnext(logic [3:0] c, bit r, bit l, logic [3:0] d,
                                        bit pe, bit te, bit dec);
      if (!r) return 4'd0;
      if (!l) return d;
      if (pe && te) begin
         if (dec) return (c >= 4'd9) ? 4'd0 : c + 4'd1;
         return c + 4'd1;
      end
      return c;
   endfunction

   function automatic bit mterm(logic [3:0] c, bit te, bit dec);
      return te && (c == (dec ? 4'd9 : 4'd15));
   endfunction

   task automatic chk(bit ok, string tag, string what, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // driver: applies one cycle of inputs and queues the expected outcome
   task automatic step(bit r, bit l, logic [3:0] dl, logic [3:0] dh,
                       bit pe, bit te, string tag);
      exp_t e;
      bit   ta_lo, tb_lo;
      @(negedge clk);
      rst_n = r; load_n = l; din_lo = dl; din_hi = dh; cnt_en = pe; carry_in = te;
      ta_lo = mterm(ma_l, te, 1'b0);
      tb_lo = mterm(mb_l, te, 1'b1);
      ma_h = mnext(ma_h, r, l, dh, pe, ta_lo, 1'b0);
      ma_l = mnext(ma_l, r, l, dl, pe, te, 1'b0);
      mb_h = mnext(mb_h, r, l, dh, pe, tb_lo, 1'b1);
      mb_l = mnext(mb_l, r, l, dl, pe, te, 1'b1);
      e.al = ma_l; e.ah = ma_h; e.bl = mb_l; e.bh = mb_h;
      e.ta = mterm(ma_h, mterm(ma_l, te, 1'b0), 1'b0);
      e.tb = mterm(mb_h, mterm(mb_l, te, 1'b1), 1'b1);
      e.tag = tag;
      q.push_back(e);
   endtask

   // monitor: compares after each edge once outputs have settled
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk({a_lo, a_hi, b_lo, b_hi, ca_hi, cb_hi} == {e.al, e.ah, e.bl, e.bh, e.ta, e.tb},
                e.tag, "{a_hi,a_lo,b_hi,b_lo,ta,tb}",
                int'({a_hi, a_lo, b_hi, b_lo, ca_hi, cb_hi}),
                int'({e.ah, e.al, e.bh, e.bl, e.ta, e.tb}));
         end
      end
   end

   initial begin
      #(8 * 150000);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R7: reset state and reset over load
      step(0, 1, 4'd0, 4'd0, 0, 0, "R7");
      step(0, 0, 4'd7, 4'd5, 1, 1, "R7 over load");
      // R1 R2 R6 R10: full chained sweep, binary wraps at 256, decade at 100
      for (int i = 0; i < 256; i++) step(1, 1, 4'd0, 4'd0, 1, 1, "R10 R1 R2 R6");
      // R5: hold with either enable low
      step(1, 1, 4'd0, 4'd0, 0, 1, "R5 cnt_en low");
      step(1, 1, 4'd0, 4'd0, 0, 1, "R5 cnt_en low");
      step(1, 1, 4'd0, 4'd0, 1, 0, "R5 carry_in low");
      step(1, 1, 4'd0, 4'd0, 1, 0, "R5 carry_in low");
      // R4: load with enables low; R6 terminal with cnt_en low
      step(1, 0, 4'd15, 4'd9, 0, 1, "R4 load idle");
      step(1, 0, 4'd9, 4'd9, 0, 1, "R6 last value");
      step(1, 1, 4'd0, 4'd0, 0, 1, "R6 cnt_en ignored");
      step(1, 1, 4'd0, 4'd0, 1, 1, "R2 wrap 99");
      // R3: every illegal decade value folds to 0 in one step
      for (int v = 10; v < 16; v++) begin
         step(1, 0, 4'(v), 4'd2, 1, 1, "R4 load illegal");
         step(1, 1, 4'd0, 4'd0, 1, 1, "R3 fold");
      end
      // preset for mid-cycle clear
      step(1, 0, 4'd5, 4'd3, 0, 0, "R4 preset");
      @(negedge clk);
      load_n = 1'b1; cnt_en = 1'b0; carry_in = 1'b0;
      #2 rst_n = 1'b0;
      #1;
      chk({a_hi, a_lo} == 8'h00, "R8", "async clear mid-cycle", int'({a_hi, a_lo}), 0);
      chk({b_hi, b_lo} == 8'h35, "R9", "sync clear waits", int'({b_hi, b_lo}), 8'h35);
      @(posedge clk);
      #2;
      chk({b_hi, b_lo} == 8'h00, "R9", "sync clear at edge", int'({b_hi, b_lo}), 0);
      chk({a_hi, a_lo} == 8'h00, "R8", "async stays clear", int'({a_hi, a_lo}), 0);
      ma_l = 0; ma_h = 0; mb_l = 0; mb_h = 0;
      // R1: counting resumes after clear
      for (int i = 0; i < 12; i++) step(1, 1, 4'd0, 4'd0, 1, 1, "R1 resume");
      wait (q.size() == 0);
      @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule